// File: doc/BRIEF.md
# Pipelined Carry-Select Add/Subtract/Compare Unit

This block performs integer addition, subtraction and comparison on two operands of a parameterised width (64 bits by default). The operands are cut into equal chunks of 16 bits each. Every chunk forms two sums at the same time, one that assumes no incoming carry and one that assumes an incoming carry. A chain of multiplexers then picks one sum per chunk. The pick for a chunk depends on the carry bit of the sum already chosen in the chunk below it. Subtraction inverts the second operand and forces the carry into the lowest chunk high. Comparison uses the same subtract datapath and adds no arithmetic of its own.

Operands are captured on one clock edge. The selected sum then has a full cycle to settle before it is registered. Each operation therefore appears at the outputs exactly two cycles after it was offered. A new operation can be accepted on every cycle. Along with the result, the unit returns the carry out of the top chunk, zero and negative flags, an unsigned-borrow flag and a signed less-than flag. It also returns a write strobe that tells the surrounding pipeline whether the result is meant to be written back.

Top module: `csel_addsub`

## Requirements
- R1: Operation codes on `in_op` are 2'b00 add, 2'b01 subtract, 2'b10 compare, and 2'b11 handled as add. For an add, `out_res` is (A + B + `in_cin`) modulo 2^W and `out_cout` is bit W of that sum.
- R2: For a subtract, `out_res` is (A − B) modulo 2^W. The value of `in_cin` has no effect. `out_cout` is 1 exactly when A ≥ B as unsigned numbers.
- R3: A compare produces the same `out_res`, `out_cout` and flags as a subtract of the same operands, but keeps `out_wr` low. For add and subtract, `out_wr` equals `out_valid`.
- R4: For every operation, `out_zero` is 1 exactly when `out_res` is all zeros, and `out_neg` equals bit W−1 of `out_res`.
- R5: `out_borrow` is 1 exactly when A < B as unsigned numbers for a subtract or compare. It is 0 for an add.
- R6: `out_less` is 1 exactly when A < B as two's-complement signed numbers for a subtract or compare. It is 0 for an add.
- R7: `out_valid` equals `in_valid` from two cycles earlier. Back-to-back operations are accepted on every cycle, and gaps in `in_valid` appear as gaps two cycles later.
- R8: While `rst` is high, `in_valid` is ignored. In the first two cycles after `rst` falls, `out_valid` and `out_wr` are low unless `in_valid` was raised during those cycles.
- R9: Carries and borrows travel across every chunk boundary within the same two-cycle latency. For example, all-ones + 1 gives zero with `out_cout` = 1, and 0 − 1 gives all-ones with `out_borrow` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered this cycle |
| in_op | input | 2 | Operation code: 00 add, 01 subtract, 10 compare, 11 add |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cin | input | 1 | Carry input, used by add only |
| out_valid | output | 1 | Result of the operation offered two cycles earlier is present |
| out_wr | output | 1 | Result should be written back (add or subtract) |
| out_res | output | W | Sum or difference |
| out_cout | output | 1 | Carry out of the top chunk |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Most significant bit of the result |
| out_borrow | output | 1 | Unsigned A < B (subtract and compare) |
| out_less | output | 1 | Signed A < B (subtract and compare) |

## Verification
If a chunk picks the wrong one of its two sums, the result is off by exactly 2^(16·k) for that chunk. The error reaches `out_res`, and usually `out_cout` or the flags, two cycles after the operands went in. Operand patterns that make a carry ripple into every chunk expose this at once. A fault in the valid or operation pipeline shows up in the cycle it reaches the output, as a shifted, missing or extra `out_valid` or `out_wr`. A small configuration (6 bits in 2-bit chunks) is swept over every operand pair and every operation. Directed 64-bit vectors cover the carry, signed and unsigned extremes.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    function automatic logic op_subtracts(op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/csel_chunk.sv
// One chunk of the carry-select adder: both candidate sums in parallel.
module csel_chunk #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic [CW:0]   sum_c0,
    output logic [CW:0]   sum_c1
);
    assign sum_c0 = {1'b0, a} + {1'b0, b};
    assign sum_c1 = {1'b0, a} + {1'b0, b} + {{CW{1'b0}}, 1'b1};
endmodule

// File: rtl/csel_chain.sv
// Row of chunks with a carry-selection chain from the bottom chunk upward.
module csel_chain #(
    parameter int W  = 64,
    parameter int CW = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NCH = W / CW;

    logic [NCH:0] sel_c;
    assign sel_c[0] = cin;

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        logic [CW:0] s0;
        logic [CW:0] s1;
        logic [CW:0] pick;

        csel_chunk #(.CW(CW)) u_chunk (
            .a      (a[g*CW +: CW]),
            .b      (b[g*CW +: CW]),
            .sum_c0 (s0),
            .sum_c1 (s1)
        );

        assign pick            = sel_c[g] ? s1 : s0;
        assign sum[g*CW +: CW] = pick[CW-1:0];
        assign sel_c[g+1]      = pick[CW];
    end

    assign cout = sel_c[NCH];
endmodule

// File: rtl/csel_flags.sv
// Condition flags derived from the registered result.
module csel_flags #(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    input  logic         cout,
    input  logic         ovf,
    input  logic         is_sub,
    output logic         zero,
    output logic         neg,
    output logic         borrow,
    output logic         less
);
    assign zero   = (res == '0);
    assign neg    = res[W-1];
    assign borrow = is_sub & ~cout;
    assign less   = is_sub & (res[W-1] ^ ovf);
endmodule

// File: rtl/csel_addsub.sv
module csel_addsub #(
    parameter int W  = 64,
    parameter int CW = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         in_cin,
    output logic         out_valid,
    output logic         out_wr,
    output logic [W-1:0] out_res,
    output logic         out_cout,
    output logic         out_zero,
    output logic         out_neg,
    output logic         out_borrow,
    output logic         out_less
);
    import csel_pkg::*;

    typedef struct packed {
        logic         v;
        op_e          op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
    } cap_t;

    typedef struct packed {
        logic         v;
        logic         wr;
        logic         sub;
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
    } res_t;

    cap_t cap_d, cap_q;
    res_t res_d, res_q;

    // Operand conditioning for the shared datapath
    logic         sub_w;
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W-1:0] sum_w;
    logic         cout_w;

    assign sub_w = op_subtracts(cap_q.op);
    assign b_eff = sub_w ? ~cap_q.b : cap_q.b;
    assign c_eff = sub_w ? 1'b1 : cap_q.cin;

    csel_chain #(.W(W), .CW(CW)) u_chain (
        .a    (cap_q.a),
        .b    (b_eff),
        .cin  (c_eff),
        .sum  (sum_w),
        .cout (cout_w)
    );

    always_comb begin
        cap_d     = cap_q;
        cap_d.v   = in_valid;
        cap_d.op  = op_e'(in_op);
        cap_d.a   = in_a;
        cap_d.b   = in_b;
        cap_d.cin = in_cin;

        res_d      = res_q;
        res_d.v    = cap_q.v;
        res_d.wr   = cap_q.v && (cap_q.op != OP_CMP);
        res_d.sub  = sub_w;
        res_d.res  = sum_w;
        res_d.cout = cout_w;
        res_d.ovf  = (cap_q.a[W-1] == b_eff[W-1]) && (sum_w[W-1] != cap_q.a[W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            res_q <= '0;
        end else begin
            cap_q <= cap_d;
            res_q <= res_d;
        end
    end

    csel_flags #(.W(W)) u_flags (
        .res    (res_q.res),
        .cout   (res_q.cout),
        .ovf    (res_q.ovf),
        .is_sub (res_q.sub),
        .zero   (out_zero),
        .neg    (out_neg),
        .borrow (out_borrow),
        .less   (out_less)
    );

    assign out_valid = res_q.v;
    assign out_wr    = res_q.wr;
    assign out_res   = res_q.res;
    assign out_cout  = res_q.cout;
endmodule

// File: rtl/csel_addsub_chk.sv
module csel_addsub_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   in_op,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         in_cin,
    input logic         out_valid,
    input logic         out_wr,
    input logic [W-1:0] out_res,
    input logic         out_cout,
    input logic         out_zero,
    input logic         out_neg,
    input logic         out_borrow,
    input logic         out_less
);
    logic [1:0]   age;
    logic         warm;
    logic [W-1:0] diff_p1, diff_p2;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age >= 2'd2);

    always_ff @(posedge clk) begin
        diff_p1 <= in_a - in_b;
        diff_p2 <= diff_p1;
    end

    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2)));

    a_r1_add_sum: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(in_op, 2) != 2'b01 && $past(in_op, 2) != 2'b10)
        |-> ({out_cout, out_res} == ({1'b0, $past(in_a, 2)} + {1'b0, $past(in_b, 2)}
                                     + (W+1)'($past(in_cin, 2)))));

    a_r2_sub_diff: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(in_op, 2) == 2'b01)
        |-> (out_res == diff_p2 && out_cout == ($past(in_a, 2) >= $past(in_b, 2))));

    a_r3_cmp_nowrite: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(in_op, 2) == 2'b10) |-> !out_wr);

    a_r3_wr_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> out_valid);

    a_r4_zero_neg: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && ($past(in_op, 2) == 2'b01 || $past(in_op, 2) == 2'b10))
        |-> (out_zero == ($past(in_a, 2) == $past(in_b, 2)) && out_neg == diff_p2[W-1]));

    a_r5_borrow: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && ($past(in_op, 2) == 2'b01 || $past(in_op, 2) == 2'b10))
        |-> (out_borrow == ($past(in_a, 2) < $past(in_b, 2))));

    a_r6_less: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && ($past(in_op, 2) == 2'b01 || $past(in_op, 2) == 2'b10))
        |-> (out_less == ($signed($past(in_a, 2)) < $signed($past(in_b, 2)))));

    a_r8_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_wr));
endmodule

bind csel_addsub csel_addsub_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_cin     (in_cin),
    .out_valid  (out_valid),
    .out_wr     (out_wr),
    .out_res    (out_res),
    .out_cout   (out_cout),
    .out_zero   (out_zero),
    .out_neg    (out_neg),
    .out_borrow (out_borrow),
    .out_less   (out_less)
);

// File: tb/csel_addsub_tb.sv
module csel_addsub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 6;
    localparam int SCW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // 64-bit unit
    logic        b_iv, b_cin, b_ov, b_wr, b_co, b_z, b_n, b_bo, b_lt;
    logic [1:0]  b_op;
    logic [63:0] b_a, b_b, b_res;
    // small unit
    logic          s_iv, s_cin, s_ov, s_wr, s_co, s_z, s_n, s_bo, s_lt;
    logic [1:0]    s_op;
    logic [SW-1:0] s_a, s_b, s_res;

    csel_addsub u_dut (
        .clk(clk), .rst(rst), .in_valid(b_iv), .in_op(b_op), .in_a(b_a), .in_b(b_b),
        .in_cin(b_cin), .out_valid(b_ov), .out_wr(b_wr), .out_res(b_res), .out_cout(b_co),
        .out_zero(b_z), .out_neg(b_n), .out_borrow(b_bo), .out_less(b_lt));

    csel_addsub #(.W(SW), .CW(SCW)) u_dut_small (
        .clk(clk), .rst(rst), .in_valid(s_iv), .in_op(s_op), .in_a(s_a), .in_b(s_b),
        .in_cin(s_cin), .out_valid(s_ov), .out_wr(s_wr), .out_res(s_res), .out_cout(s_co),
        .out_zero(s_z), .out_neg(s_n), .out_borrow(s_bo), .out_less(s_lt));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic        v;
        logic        we;
        logic [1:0]  op;
        logic [63:0] res;
        logic        cout, z, n, bo, lt;
        string       tag;
    } exp_t;

    exp_t bp0, bp1, sp0, sp1;

    function automatic exp_t model(int w, logic v, logic [1:0] op,
                                   logic [63:0] a, logic [63:0] b, logic cin);
        exp_t        e;
        logic [64:0] mask, bb, sum;
        logic [63:0] msb;
        logic        sub;
        mask  = (65'd1 << w) - 65'd1;
        sub   = (op == 2'b01) || (op == 2'b10);
        bb    = sub ? (~{1'b0, b}) & mask : {1'b0, b} & mask;
        sum   = ({1'b0, a} & mask) + bb + (sub ? 65'd1 : {64'd0, cin});
        msb   = 64'd1 << (w - 1);
        e.v   = v;
        e.we  = v && (op != 2'b10);
        e.op  = op;
        e.res = sum[63:0] & mask[63:0];
        e.cout = sum[w];
        e.z   = (e.res == 64'd0);
        e.n   = e.res[w-1];
        e.bo  = sub && (a < b);
        e.lt  = sub && ((a ^ msb) < (b ^ msb));
        e.tag = (op == 2'b01) ? "R2" : (op == 2'b10) ? "R3" : "R1";
        return e;
    endfunction

    task automatic chk(bit ok, string what, logic [64:0] act, logic [64:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic compare(exp_t e, logic ov, logic we, logic [63:0] res, logic co,
                           logic z, logic n, logic bo, logic lt);
        chk(ov == e.v, "R7 out_valid", {64'd0, ov}, {64'd0, e.v});
        chk(we == e.we, "R3 out_wr", {64'd0, we}, {64'd0, e.we});
        if (e.v) begin
            chk({co, res} == {e.cout, e.res}, {e.tag, " result/carry"},
                {co, res}, {e.cout, e.res});
            chk({z, n} == {e.z, e.n}, "R4 zero/neg", {63'd0, z, n}, {63'd0, e.z, e.n});
            chk(bo == e.bo, "R5 borrow", {64'd0, bo}, {64'd0, e.bo});
            chk(lt == e.lt, "R6 less", {64'd0, lt}, {64'd0, e.lt});
        end
    endtask

    task automatic step_big(logic v, logic [1:0] op, logic [63:0] a, logic [63:0] b,
                            logic cin, string tag = "");
        @(negedge clk);
        compare(bp1, b_ov, b_wr, b_res, b_co, b_z, b_n, b_bo, b_lt);
        bp1 = bp0;
        bp0 = model(64, v, op, a, b, cin);
        if (tag != "") bp0.tag = tag;
        b_iv = v; b_op = op; b_a = a; b_b = b; b_cin = cin;
    endtask

    task automatic step_small(logic v, logic [1:0] op, logic [SW-1:0] a,
                              logic [SW-1:0] b, logic cin);
        @(negedge clk);
        compare(sp1, s_ov, s_wr, {{(64-SW){1'b0}}, s_res}, s_co, s_z, s_n, s_bo, s_lt);
        sp1 = sp0;
        sp0 = model(SW, v, op, {{(64-SW){1'b0}}, a}, {{(64-SW){1'b0}}, b}, cin);
        s_iv = v; s_op = op; s_a = a; s_b = b; s_cin = cin;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

    initial begin
        bp0 = model(64, 1'b0, 2'b00, 64'd0, 64'd0, 1'b0);
        bp1 = bp0; sp0 = bp0; sp1 = bp0;
        // R8: valid offered during reset must be ignored
        b_iv = 1'b1; b_op = 2'b00; b_a = '0; b_b = '0; b_cin = 1'b0;
        s_iv = 1'b1; s_op = 2'b00; s_a = '0; s_b = '0; s_cin = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!b_ov && !b_wr && !s_ov && !s_wr, "R8 outputs in reset",
            {61'd0, b_ov, b_wr, s_ov, s_wr}, 65'd0);
        b_iv = 1'b0; s_iv = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(!b_ov && !b_wr, "R8 first cycle after reset", {63'd0, b_ov, b_wr}, 65'd0);

        // R9: carries across each chunk boundary
        step_big(1'b1, 2'b00, ONES, 64'd1, 1'b0, "R9 all-ones+1");
        step_big(1'b1, 2'b00, 64'h0000_0000_0000_FFFF, 64'd1, 1'b0, "R9 boundary 1");
        step_big(1'b1, 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, "R9 boundary 2");
        step_big(1'b1, 2'b00, 64'h0000_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R9 boundary 3");
        step_big(1'b1, 2'b00, ONES, 64'd0, 1'b1, "R9 carry-in ripple");
        step_big(1'b1, 2'b01, 64'd0, 64'd1, 1'b0, "R9 0-1 borrow");
        // R1 add extremes, gap for R7, reserved code as add
        step_big(1'b1, 2'b00, SMAX, 64'd1, 1'b0);
        step_big(1'b0, 2'b00, 64'd5, 64'd6, 1'b0);
        step_big(1'b1, 2'b11, ONES, ONES, 1'b1);
        step_big(1'b1, 2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1);
        // R2 carry-in ignored on subtract
        step_big(1'b1, 2'b01, 64'h0001_0000_0000_0000, 64'd1, 1'b0);
        step_big(1'b1, 2'b01, 64'h0001_0000_0000_0000, 64'd1, 1'b1);
        step_big(1'b1, 2'b01, SMIN, 64'd1, 1'b0);
        // R3/R5/R6 compare at signed and unsigned extremes
        step_big(1'b1, 2'b10, SMIN, SMAX, 1'b0);
        step_big(1'b1, 2'b10, SMAX, SMIN, 1'b1);
        step_big(1'b1, 2'b10, ONES, ONES, 1'b0);
        step_big(1'b1, 2'b10, 64'd0, ONES, 1'b0);
        step_big(1'b1, 2'b10, ONES, 64'd0, 1'b0);
        step_big(1'b0, 2'b00, 64'd0, 64'd0, 1'b0);
        step_big(1'b0, 2'b00, 64'd0, 64'd0, 1'b0);

        // Exhaustive sweep of the small configuration (R1..R7)
        for (int a = 0; a < (1 << SW); a++) begin
            for (int b = 0; b < (1 << SW); b++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [1:0] op;
                    logic       cin;
                    logic       v;
                    op  = (k < 2) ? 2'b00 : (k == 2) ? 2'b01 : 2'b10;
                    cin = (k < 2) ? k[0] : a[0];
                    v   = ((a + b + k) % 5) != 4;
                    step_small(v, op, SW'(a), SW'(b), cin);
                end
            end
        end
        step_small(1'b0, 2'b00, '0, '0, 1'b0);
        step_small(1'b0, 2'b00, '0, '0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule